// File: doc/BRIEF.md
# DDR Secure Region Address Filter

This block sits in front of a DRAM port and decides, for every access, whether it may proceed. Software programs eight address windows, each described by a first and a last megabyte index (both inclusive), plus a control word. The control word marks which windows are restricted to secure masters, sets the policy for memory that no window covers, and carries a global bypass that opens the whole address space.

Configuration enters through a single write port. Every write carries a word index and a 32-bit value in which the upper half is a per-bit write mask for the lower half. Only the bits whose mask bit is set change, so software can update one field without a read-modify-write. Every cycle, an access presents an address and a secure flag. One cycle later, the block raises `acc_deny` if a non-secure master touched restricted memory.

Top module: `ddr_sec_filter`

## Requirements
- R1: After reset every window bound, every secure-map bit, the outside policy and the bypass are zero, and `acc_deny` is 0. With that state all eight windows cover megabyte 0, and no access is denied.
- R2: A write with `cfg_we`=1 updates word `cfg_idx` so that data bit k (`cfg_wdata[k]`) replaces stored bit k only where mask bit `cfg_wdata[16+k]` is 1. Every other bit of the word keeps its value.
- R3: Word indices 0 to 7 hold the first megabyte of windows 0 to 7, and indices 8 to 15 hold the last megabyte of windows 0 to 7. An address matches window n when its megabyte index `acc_addr[35:20]` is at least the first and at most the last value.
- R4: A window whose first and last values are both 0 covers exactly addresses 0x0 to 0xFFFFF.
- R5: A window whose first value exceeds its last value matches no address.
- R6: Bits 0 to 7 of word 16 mark windows 0 to 7 as secure-only (1) or open (0). A non-secure access that matches a secure window is denied.
- R7: Bit 8 of word 16 is the policy for addresses that match no window. When it is 1, non-secure accesses there are denied. When it is 0, they are allowed.
- R8: If several windows match, the address is secure when any matching window is secure. An address that matches only open windows is allowed even when bit 8 of word 16 is 1.
- R9: When bit 9 of word 16 is 1, no access is denied.
- R10: An access with `acc_secure`=1 is never denied.
- R11: `acc_deny` reflects the access presented in the previous cycle, judged with the configuration held before that cycle's edge. A configuration write therefore affects accesses from the next cycle on, not the access presented in the same cycle.
- R12: Writes to word indices above 16 change no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 5 | Configuration word index |
| cfg_wdata | input | 32 | [31:16] write mask, [15:0] data |
| acc_addr | input | 36 | Access byte address |
| acc_secure | input | 1 | 1 when the access comes from a secure master |
| acc_deny | output | 1 | Registered: 1 when the previous access is refused |

## Verification
A configuration write and an access can land in the same cycle. The bench provokes this by setting the bypass bit in the same cycle as a non-secure access into a secure window. It expects that access to still be refused and the next identical access to pass. Around this case, sweeps over megabyte indices 0 to 47 with both secure-flag values run under several window layouts: overlaps, inverted bounds, zero-size windows at megabyte 0, and both outside policies. The bench compares every result with an arithmetic model built from the requirements.

// File: rtl/ddr_sec_pkg.sv
package ddr_sec_pkg;
  localparam int CFG_DATA_W = 16;
  localparam int MB_SHIFT   = 20;

  // Masked merge: bits with a set mask take the new data, others hold.
  function automatic logic [CFG_DATA_W-1:0] masked_merge(
    input logic [CFG_DATA_W-1:0] old_val,
    input logic [CFG_DATA_W-1:0] new_val,
    input logic [CFG_DATA_W-1:0] mask
  );
    return (old_val & ~mask) | (new_val & mask);
  endfunction
endpackage

// File: rtl/ddr_sec_regs.sv
module ddr_sec_regs
  import ddr_sec_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int MB_W    = 16,
  localparam int IDX_W  = $clog2(2*NUM_WIN+1),
  localparam int CTRL_W = NUM_WIN + 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [IDX_W-1:0]                cfg_idx,
  input  logic [31:0]                     cfg_wdata,
  output logic [NUM_WIN-1:0][MB_W-1:0]    win_first,
  output logic [NUM_WIN-1:0][MB_W-1:0]    win_last,
  output logic [NUM_WIN-1:0]              win_sec,
  output logic                            outside_sec,
  output logic                            bypass
);
  logic [2*NUM_WIN-1:0][MB_W-1:0] bound_q, bound_d;
  logic [CTRL_W-1:0]              ctrl_q, ctrl_d;
  logic [CFG_DATA_W-1:0]          wr_data, wr_mask;

  assign wr_data = cfg_wdata[CFG_DATA_W-1:0];
  assign wr_mask = cfg_wdata[2*CFG_DATA_W-1:CFG_DATA_W];

  always_comb begin
    bound_d = bound_q;
    ctrl_d  = ctrl_q;
    for (int i = 0; i < 2*NUM_WIN; i++) begin
      if (cfg_idx == IDX_W'(i))
        bound_d[i] = MB_W'(masked_merge(CFG_DATA_W'(bound_q[i]), wr_data, wr_mask));
    end
    if (cfg_idx == IDX_W'(2*NUM_WIN))
      ctrl_d = CTRL_W'(masked_merge(CFG_DATA_W'(ctrl_q), wr_data, wr_mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound_q <= '0;
      ctrl_q  <= '0;
    end else if (cfg_we) begin
      bound_q <= bound_d;
      ctrl_q  <= ctrl_d;
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_out
    assign win_first[w] = bound_q[w];
    assign win_last[w]  = bound_q[w+NUM_WIN];
  end
  assign win_sec     = ctrl_q[NUM_WIN-1:0];
  assign outside_sec = ctrl_q[NUM_WIN];
  assign bypass      = ctrl_q[NUM_WIN+1];

  // R2: a write with an all-zero mask leaves every stored bit untouched
  p_zero_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wr_mask == '0) |=> ($stable(bound_q) && $stable(ctrl_q)));

  // R12: indices past the control word are ignored
  p_high_idx_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_idx > IDX_W'(2*NUM_WIN)) |=> ($stable(bound_q) && $stable(ctrl_q)));

  // R9: a masked write of the bypass bit lands exactly
  p_bypass_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_idx == IDX_W'(2*NUM_WIN) && wr_mask[NUM_WIN+1])
      |=> (bypass == $past(wr_data[NUM_WIN+1])));
endmodule

// File: rtl/ddr_sec_win_match.sv
module ddr_sec_win_match #(
  parameter int MB_W = 16
) (
  input  logic [MB_W-1:0] mb_idx,
  input  logic [MB_W-1:0] first_mb,
  input  logic [MB_W-1:0] last_mb,
  output logic            hit
);
  // Inclusive on both ends; an inverted window can never satisfy both.
  assign hit = (mb_idx >= first_mb) && (mb_idx <= last_mb);
endmodule

// File: rtl/ddr_sec_policy.sv
module ddr_sec_policy #(
  parameter int NUM_WIN = 8
) (
  input  logic [NUM_WIN-1:0] hits,
  input  logic [NUM_WIN-1:0] win_sec,
  input  logic               outside_sec,
  input  logic               bypass,
  input  logic               acc_secure,
  output logic               deny
);
  logic any_hit, sec_hit, region_secure;

  always_comb begin
    any_hit       = |hits;
    sec_hit       = |(hits & win_sec);
    region_secure = any_hit ? sec_hit : outside_sec;
    deny          = !bypass && !acc_secure && region_secure;
  end
endmodule

// File: rtl/ddr_sec_filter.sv
module ddr_sec_filter
  import ddr_sec_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 36,
  localparam int MB_W   = ADDR_W - MB_SHIFT,
  localparam int IDX_W  = $clog2(2*NUM_WIN+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_secure,
  output logic              acc_deny
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic [NUM_WIN-1:0][MB_W-1:0] win_first, win_last;
  logic [NUM_WIN-1:0]           win_sec, hits;
  logic                         outside_sec, bypass;
  logic [MB_W-1:0]              mb_idx;
  logic                         deny_d, deny_q;
  logic [MB_SHIFT-1:0]          unused_offset;

  assign mb_idx        = acc_addr[ADDR_W-1:MB_SHIFT];
  assign unused_offset = acc_addr[MB_SHIFT-1:0];

  ddr_sec_regs #(.NUM_WIN(NUM_WIN), .MB_W(MB_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .cfg_wdata   (cfg_wdata),
    .win_first   (win_first),
    .win_last    (win_last),
    .win_sec     (win_sec),
    .outside_sec (outside_sec),
    .bypass      (bypass)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    ddr_sec_win_match #(.MB_W(MB_W)) u_match (
      .mb_idx   (mb_idx),
      .first_mb (win_first[w]),
      .last_mb  (win_last[w]),
      .hit      (hits[w])
    );
  end

  ddr_sec_policy #(.NUM_WIN(NUM_WIN)) u_policy (
    .hits        (hits),
    .win_sec     (win_sec),
    .outside_sec (outside_sec),
    .bypass      (bypass),
    .acc_secure  (acc_secure),
    .deny        (deny_d)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) deny_q <= 1'b0;
    else          deny_q <= deny_d;
  end
  assign acc_deny = deny_q;

  // R10: secure masters always pass
  p_secure_pass_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    acc_secure |=> !acc_deny);

  // R9: bypass opens everything on the next result
  p_bypass_open_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    bypass |=> !acc_deny);

  // R6: non-secure hit on a secure window is refused next cycle
  p_secwin_deny_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!bypass && !acc_secure && |(hits & win_sec)) |=> acc_deny);

  // R7: unmatched address follows the outside policy
  p_outside_deny_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!bypass && !acc_secure && hits == '0 && outside_sec) |=> acc_deny);
endmodule

// File: tb/ddr_sec_filter_bench.sv
`timescale 1ns/1ps
module ddr_sec_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic [35:0] acc_addr;
  logic        acc_secure;
  logic        acc_deny;

  always #2.5 clk = ~clk;

  ddr_sec_filter u_ddr_sec_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_secure(acc_secure),
    .acc_deny(acc_deny)
  );

  logic [15:0] m_first [8];
  logic [15:0] m_last  [8];
  logic [15:0] m_ctrl;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: acc_deny=%0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic model_deny(input int mb, input logic sec);
    logic any_hit = 1'b0;
    logic sec_hit = 1'b0;
    if (m_ctrl[9] || sec) return 1'b0;
    for (int w = 0; w < 8; w++) begin
      if (m_first[w] <= mb && mb <= m_last[w]) begin
        any_hit = 1'b1;
        if (m_ctrl[w]) sec_hit = 1'b1;
      end
    end
    return any_hit ? sec_hit : m_ctrl[8];
  endfunction

  function automatic logic [15:0] mrg(input logic [15:0] o, input logic [15:0] d,
                                      input logic [15:0] m);
    return (o & ~m) | (d & m);
  endfunction

  task automatic wr(input int idx, input logic [15:0] mask, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx[4:0]; cfg_wdata = {mask, data};
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (idx < 8)       m_first[idx]  = mrg(m_first[idx], data, mask);
    else if (idx < 16) m_last[idx-8] = mrg(m_last[idx-8], data, mask);
    else if (idx == 16) m_ctrl       = mrg(m_ctrl, data, mask);
  endtask

  task automatic acc(input int mb, input logic [19:0] low, input logic sec,
                     input string req);
    @(negedge clk);
    acc_addr = {mb[15:0], low}; acc_secure = sec;
    @(posedge clk); #1;
    chk(req, acc_deny, model_deny(mb, sec));
  endtask

  task automatic sweep(input string req);
    for (int mb = 0; mb < 48; mb++)
      for (int s = 0; s < 2; s++)
        acc(mb, (mb % 2) ? 20'hFFFFF : 20'h00000, s[0], req);
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 8; w++) begin m_first[w] = '0; m_last[w] = '0; end
    m_ctrl = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    acc_addr = '0; acc_secure = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset output", acc_deny, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: cleared state denies nothing
    acc(0, 20'h12345, 1'b0, "R1");
    acc(200, 20'h0, 1'b0, "R1");
    // R4: zero-zero windows cover exactly MB 0
    wr(16, 16'h0100, 16'h0100);
    acc(0, 20'hFFFFF, 1'b0, "R4");
    acc(1, 20'h00000, 1'b0, "R4");
    // R2: mask keeps bypass clear although data sets it
    wr(16, 16'h00FF, 16'hFFFF);
    acc(0, 20'h0, 1'b0, "R2");

    // Layout A: win0 2..5 sec, win1 10..20 open, win2 inverted 30..25 sec
    wr(0, 16'hFFFF, 16'd2);  wr(8, 16'hFFFF, 16'd5);
    wr(1, 16'hFFFF, 16'd10); wr(9, 16'hFFFF, 16'd20);
    wr(2, 16'hFFFF, 16'd30); wr(10, 16'hFFFF, 16'd25);
    wr(16, 16'h01FF, 16'h0105);
    // R2: partial mask moves win1 start 10 -> 11 only
    wr(1, 16'h0001, 16'hFFFF);
    acc(10, 20'h0, 1'b0, "R2");
    acc(11, 20'h0, 1'b0, "R2");
    acc(3, 20'h0, 1'b0, "R6");
    acc(27, 20'h0, 1'b0, "R5");
    sweep("R3");
    // R7: outside open
    wr(16, 16'h0100, 16'h0000);
    acc(40, 20'h0, 1'b0, "R7");
    sweep("R7");
    // R8: win3 4..12 secure overlaps win0 and win1; outside secure again
    wr(3, 16'hFFFF, 16'd4); wr(11, 16'hFFFF, 16'd12);
    wr(16, 16'h0108, 16'h0108);
    acc(11, 20'h0, 1'b0, "R8");
    acc(15, 20'h0, 1'b0, "R8");
    sweep("R8");
    acc(11, 20'h0, 1'b1, "R10");
    // R12: high indices ignored
    wr(17, 16'hFFFF, 16'h0200);
    wr(31, 16'hFFFF, 16'hFFFF);
    acc(11, 20'h0, 1'b0, "R12");
    // R11: write and access in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'd16; cfg_wdata = {16'h0200, 16'h0200};
    acc_addr = {16'd11, 20'h0}; acc_secure = 1'b0;
    @(posedge clk); #1;
    chk("R11 same-cycle old config", acc_deny, 1'b1);
    cfg_we = 1'b0; m_ctrl[9] = 1'b1;
    acc(11, 20'h0, 1'b0, "R11");
    // R9: bypass on, then off
    sweep("R9");
    wr(16, 16'h0200, 16'h0000);
    acc(11, 20'h0, 1'b0, "R9");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule